// File: doc/BRIEF.md
# Two-Channel PCM Highway Port

This block connects a two-channel line-card codec to a time-slotted serial PCM highway. The highway bit clock also clocks the block. When a transmit frame sync arrives, the block loads the samples of both channels. It then sends them one bit per bit-clock cycle, with channel 1 first and the most significant bit first. The serial line is open drain. The port pulls the line low for a 0 bit and releases it for a 1 bit. An active-low strobe is low while the port owns the line, so it can enable an external backplane driver.

On the receive side, a separate frame sync starts the deserialiser. It samples the serial input on the falling edge of the bit clock. Each channel's byte is presented with a one-cycle valid pulse. A mode input selects the frame timing. In long-frame mode, the first bit follows the sync rising edge. In short-frame mode, it follows the sync falling edge. A power-down input releases the line at once and stops both directions.

Top module: `pcm_port`

## Requirements
- R1: With fs_short_i = 0 (long frame), a transmit frame starts at the first rising clock edge where tx_sync_i is sampled 1 after being sampled 0. The MSB of channel 1 appears on the line during the cycle after that edge.
- R2: With fs_short_i = 1 (short frame), a frame starts at the first rising edge where the sync is sampled 0 after being sampled 1. No frame starts on the sync rising edge.
- R3: The transmit order is tx_data_i[0] (channel 1) MSB first, then tx_data_i[1] (channel 2) MSB first. This gives 16 consecutive slots, one per cycle, after which the line is released. The samples are latched at the start edge.
- R4: pcm_pull_o = 1 means the line is pulled low. It is 1 only inside a slot whose bit is 0. A 1 bit and any idle time leave the line released (0).
- R5: pcm_valid_no is 0 exactly during the 16 transmit slot cycles and 1 otherwise.
- R6: While pd_i = 1, pcm_pull_o = 0 and pcm_valid_no = 1 in the same cycle, and no receive valid is produced. Frames that are in progress are abandoned.
- R7: On receive, the bit on pcm_i is sampled at each falling edge and shifted in MSB first. Channel 1's byte appears on rx_data_o[0], with rx_valid_o[0] high for one cycle, after the 8th rising edge following the receive start edge.
- R8: Channel 2's byte appears on rx_data_o[1], with a one-cycle rx_valid_o[1] pulse, after the 16th rising edge. At most one valid bit is high at a time, and rx_data_o holds its value between pulses.
- R9: A new start event during a frame restarts that direction at bit 0. On transmit, the new samples are latched.
- R10: After reset, pcm_pull_o = 0, pcm_valid_no = 1, rx_valid_o = 0 and rx_data_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Power-down |
| fs_short_i | input | 1 | Frame mode: 0 long, 1 short |
| tx_sync_i | input | 1 | Transmit frame sync |
| rx_sync_i | input | 1 | Receive frame sync |
| tx_data_i | input | NCH x W | Transmit samples, index 0 = channel 1 |
| pcm_i | input | 1 | Serial receive data |
| pcm_pull_o | output | 1 | 1 = pull serial line low |
| pcm_valid_no | output | 1 | Low while the port drives slots |
| rx_data_o | output | NCH x W | Received samples, index 0 = channel 1 |
| rx_valid_o | output | NCH | One-cycle pulse per received channel |

## Verification
The assertions assume the following about the inputs:
- The syncs and pcm_i change only between rising edges.
- fs_short_i changes only while both directions are idle.
- pd_i is the only input that may act within a cycle.

The stimulus meets these conditions:
- It drives every input shortly after each rising edge.
- It switches the frame mode only between frames.
- It lowers a long-frame sync before it raises the next one.

A behavioural model in the bench tracks slot positions and received bits as integers and is compared on every falling edge. The directed sequences cover truncated frames and power-down pulses in the middle of a frame.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic {
    FS_LONG  = 1'b0,
    FS_SHORT = 1'b1
  } fs_mode_e;
endpackage

// File: rtl/pcm_sync_edge.sv
module pcm_sync_edge
  import pcm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic short_i,
  output logic start_o
);
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  always_comb begin
    if (fs_mode_e'(short_i) == FS_SHORT) start_o = sync_q & ~sync_i;
    else                                 start_o = sync_i & ~sync_q;
  end
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int W   = 8,
  parameter int NCH = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    pd_i,
  input  logic [NCH-1:0][W-1:0]   data_i,
  output logic                    bit_o,
  output logic                    active_o
);
  localparam int FRAME = NCH * W;
  localparam int CW    = $clog2(FRAME);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  logic [FRAME-1:0] word, sreg_q;
  logic [CW-1:0]    cnt_q;

  // channel 1 lands in the top bits so it leaves first
  for (genvar c = 0; c < NCH; c++) begin : g_pack
    assign word[FRAME-1-c*W -: W] = data_i[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q   <= '0;
      cnt_q    <= '0;
      active_o <= 1'b0;
    end else if (pd_i) begin
      active_o <= 1'b0;
    end else if (start_i) begin
      sreg_q   <= word;
      cnt_q    <= '0;
      active_o <= 1'b1;
    end else if (active_o) begin
      sreg_q <= sreg_q << 1;
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == LAST) active_o <= 1'b0;
    end
  end

  assign bit_o = sreg_q[FRAME-1];
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int W   = 8,
  parameter int NCH = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    pd_i,
  input  logic                    bit_i,
  output logic [NCH-1:0][W-1:0]   data_o,
  output logic [NCH-1:0]          valid_o
);
  localparam int FRAME = NCH * W;
  localparam int CW    = $clog2(FRAME);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  logic          bit_q, active_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sreg_q, nxt;
  logic [NCH-1:0] hit;

  // sample mid-bit, away from the launching rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= 1'b0;
    else         bit_q <= bit_i;
  end

  assign nxt = {sreg_q[W-2:0], bit_q};

  for (genvar c = 0; c < NCH; c++) begin : g_hit
    assign hit[c] = active_q & ~pd_i & ~start_i & (cnt_q == CW'(c * W + W - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sreg_q   <= '0;
    end else if (pd_i) begin
      active_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      sreg_q <= nxt;
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == LAST) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= '0;
    end else begin
      valid_o <= hit;
      for (int c = 0; c < NCH; c++) begin
        if (hit[c]) data_o[c] <= nxt;
      end
    end
  end
endmodule

// File: rtl/pcm_port.sv
module pcm_port #(
  parameter int W   = 8,
  parameter int NCH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pd_i,
  input  logic                  fs_short_i,
  input  logic                  tx_sync_i,
  input  logic                  rx_sync_i,
  input  logic [NCH-1:0][W-1:0] tx_data_i,
  input  logic                  pcm_i,
  output logic                  pcm_pull_o,
  output logic                  pcm_valid_no,
  output logic [NCH-1:0][W-1:0] rx_data_o,
  output logic [NCH-1:0]        rx_valid_o
);
  logic tx_start, rx_start, tx_bit, tx_active;

  pcm_sync_edge u_tx_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(tx_sync_i),
    .short_i(fs_short_i), .start_o(tx_start)
  );

  pcm_sync_edge u_rx_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(rx_sync_i),
    .short_i(fs_short_i), .start_o(rx_start)
  );

  pcm_tx_shift #(.W(W), .NCH(NCH)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tx_start), .pd_i(pd_i),
    .data_i(tx_data_i), .bit_o(tx_bit), .active_o(tx_active)
  );

  pcm_rx_deser #(.W(W), .NCH(NCH)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(rx_start), .pd_i(pd_i),
    .bit_i(pcm_i), .data_o(rx_data_o), .valid_o(rx_valid_o)
  );

  // power-down acts combinationally so the line is freed at once
  assign pcm_valid_no = ~(tx_active & ~pd_i);
  assign pcm_pull_o   = tx_active & ~pd_i & ~tx_bit;
endmodule

// File: rtl/pcm_port_chk.sv
module pcm_port_chk #(
  parameter int NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           pd_i,
  input logic           tx_start_i,
  input logic           pcm_pull_i,
  input logic           pcm_valid_ni,
  input logic [NCH-1:0] rx_valid_i
);
  a_r6_pd_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |-> (pcm_valid_ni && !pcm_pull_i));

  a_r4_pull_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_pull_i |-> !pcm_valid_ni);

  a_r5_slot_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pcm_valid_ni) |-> $past(tx_start_i));

  a_r8_rx_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_valid_i));

  a_r7_rx_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i[0] |=> !rx_valid_i[0]);

  a_r6_no_rx_in_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_valid_i) |-> !$past(pd_i));
endmodule

bind pcm_port pcm_port_chk #(.NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pd_i(pd_i), .tx_start_i(tx_start),
  .pcm_pull_i(pcm_pull_o), .pcm_valid_ni(pcm_valid_no), .rx_valid_i(rx_valid_o)
);

// File: tb/pcm_port_tb_top.sv
module pcm_port_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pd = 1'b0, fs_short = 1'b0, tx_sync = 1'b0, rx_sync = 1'b0, pcm_in = 1'b1;
  logic [7:0] t1 = '0, t2 = '0;
  logic pull, valid_n;
  logic [1:0][7:0] rx_data;
  logic [1:0] rx_valid;

  int checks = 0, errors = 0;
  string tag = "R10";

  always #2.5 clk = ~clk;

  pcm_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pd_i(pd), .fs_short_i(fs_short),
    .tx_sync_i(tx_sync), .rx_sync_i(rx_sync), .tx_data_i({t2, t1}),
    .pcm_i(pcm_in), .pcm_pull_o(pull), .pcm_valid_no(valid_n),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  // behavioural reference
  int tx_idx = -1, rx_idx = -1;
  logic [15:0] tx_word = '0;
  logic [7:0] acc = '0;
  logic txs_q = 1'b0, rxs_q = 1'b0, last_bit = 1'b0;
  logic [1:0][7:0] e_rx = '0;
  logic [1:0] e_vld = '0;

  function automatic logic is_start(logic s, logic q);
    return fs_short ? (q && !s) : (s && !q);
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      tx_idx = -1; rx_idx = -1; txs_q = 0; rxs_q = 0; e_rx = '0; e_vld = '0;
    end else begin
      logic ts, rs;
      ts = is_start(tx_sync, txs_q);
      rs = is_start(rx_sync, rxs_q);
      e_vld = '0;
      if (pd) tx_idx = -1;
      else if (ts) begin tx_idx = 0; tx_word = {t1, t2}; end
      else if (tx_idx >= 0) tx_idx = (tx_idx == 15) ? -1 : tx_idx + 1;
      if (pd) rx_idx = -1;
      else if (rs) rx_idx = 0;
      else if (rx_idx >= 0) begin
        acc = {acc[6:0], last_bit};
        rx_idx++;
        if (rx_idx == 8) begin e_rx[0] = acc; e_vld[0] = 1'b1; end
        if (rx_idx == 16) begin e_rx[1] = acc; e_vld[1] = 1'b1; rx_idx = -1; end
      end
      txs_q = tx_sync;
      rxs_q = rx_sync;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      logic e_in, e_pull;
      last_bit = pcm_in;
      e_in   = (tx_idx >= 0) && !pd;
      e_pull = e_in && !tx_word[15 - (tx_idx < 0 ? 0 : tx_idx)];
      chk({tag, "/R5 valid_n"}, 32'(valid_n), 32'(!e_in));
      chk({tag, "/R4 pull"}, 32'(pull), 32'(e_pull));
      chk({tag, "/R8 rx_valid"}, 32'(rx_valid), 32'(e_vld));
      chk({tag, "/R7 rx_data"}, 32'(rx_data), 32'(e_rx));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // nbits: bits driven before returning; pd_at: bit index where pd pulses
  task automatic frame(logic sh, logic [7:0] a, logic [7:0] b,
                       logic [7:0] r1, logic [7:0] r2, int nbits, int pd_at);
    logic [15:0] rb;
    rb = {r1, r2};
    fs_short = sh;
    t1 = a; t2 = b;
    step();
    tx_sync = 1'b1; rx_sync = 1'b1;
    if (sh) begin step(); tx_sync = 1'b0; rx_sync = 1'b0; end
    for (int i = 0; i < nbits; i++) begin
      step();
      pcm_in = rb[15 - i];
      if (!sh && i == 3) begin tx_sync = 1'b0; rx_sync = 1'b0; end
      if (i == pd_at) pd = 1'b1;
      if (i == pd_at + 3) pd = 1'b0;
    end
    if (!sh && nbits < 4) begin tx_sync = 1'b0; rx_sync = 1'b0; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin step(); pcm_in = 1'b1; pd = 1'b0; end
  endtask

  initial begin
    #12;
    chk("R10 valid_n", 32'(valid_n), 32'd1);
    chk("R10 pull", 32'(pull), 32'd0);
    chk("R10 rx", 32'({rx_valid, rx_data}), 32'd0);
    step(); rst_ni = 1'b1;
    idle(3);
    tag = "R1"; frame(1'b0, 8'hA5, 8'h3C, 8'h96, 8'h0F, 16, -10); idle(4);
    tag = "R3"; frame(1'b0, 8'h00, 8'hFF, 8'hFF, 8'h00, 16, -10); idle(2);
    tag = "R2"; frame(1'b1, 8'h5A, 8'hC3, 8'h81, 8'h7E, 16, -10); idle(4);
    tag = "R2"; fs_short = 1'b1; step(); tx_sync = 1'b1; idle(3);
    tx_sync = 1'b0; step(); idle(18);
    tag = "R9"; frame(1'b0, 8'h12, 8'h34, 8'hE7, 8'h18, 5, -10);
    frame(1'b0, 8'hCD, 8'hEF, 8'h55, 8'hAA, 16, -10); idle(3);
    tag = "R9"; frame(1'b1, 8'h0F, 8'hF0, 8'h33, 8'hCC, 10, -10);
    frame(1'b1, 8'h69, 8'h96, 8'h24, 8'hDB, 16, -10); idle(3);
    tag = "R6"; frame(1'b0, 8'h00, 8'h00, 8'h11, 8'h22, 16, 6); idle(4);
    tag = "R6"; frame(1'b1, 8'hB2, 8'h4D, 8'h99, 8'h66, 16, 11); idle(4);
    tag = "R8"; frame(1'b0, 8'hFE, 8'h01, 8'hC8, 8'h37, 16, -10);
    frame(1'b0, 8'h80, 8'h7F, 8'h01, 8'h80, 16, -10); idle(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule